// File: doc/BRIEF.md
# Host-to-Microcontroller Byte Mailbox Handshake

This block carries single bytes in both directions between a host processor and a small microcontroller. The host side sees a write strobe for command bytes, a read strobe for reply bytes and a status byte showing which direction still holds an unconsumed byte. The microcontroller side sees three byte-wide ports. Port A carries the data in both directions. Port B carries the control strobes, together with a per-bit mask of the lines the microcontroller is actually driving. Port C returns handshake status. A host command also raises an interrupt request towards the microcontroller.

The microcontroller takes a command by pulling one port B line low, and posts a reply by pulling a second port B line high. Each event is an edge, found by comparing the new port B write with the previous one. It counts only when the line is marked as driven. A mode input selects between two variants. In scroll mode the port C status polarity is flipped, and two more falling-edge strobes capture the microcontroller's output byte into the low and high halves of a 16-bit scroll register.

Top module: `mbox_hs_ctrl`

## Requirements
- R1: A host write strobe stores the command byte, sets the host-sent flag and asserts `irq_o` in the following cycle. `irq_o` equals the host-sent flag at all times.
- R2: A port B write in which bit 1 goes from 1 (previous port B write) to 0, with `pb_dir_i[1]`=1, does three things. It moves the stored command byte to `pa_rdata_o`, clears the host-sent flag and deasserts `irq_o`.
- R3: A port B write in which bit 2 goes from 0 to 1, with `pb_dir_i[2]`=1, does two things. It copies the MCU output latch to `host_rdata_o` and sets the MCU-sent flag.
- R4: Edges are found against the previous port B write value, which every port B write updates whatever its direction mask. Writing the same level twice is not an edge.
- R5: A port B edge on a bit whose direction mask bit is 0 changes no latch, flag or interrupt.
- R6: A host read strobe clears the MCU-sent flag.
- R7: `host_stat_o` bit 0 is the host-sent flag and bit 1 is the MCU-sent flag. Bits 7..2 are 0.
- R8: With `mode_i`=0, `pc_rdata_o` bit 0 is the inverse of host-sent and bit 1 is MCU-sent. With `mode_i`=1 both bits are inverted from this. Bits 7..2 are 0.
- R9: With `mode_i`=1, a driven falling edge on port B bit 3 loads the MCU output latch into `scroll_o[7:0]`, and one on bit 4 loads it into `scroll_o[15:8]`. With `mode_i`=0 these edges leave `scroll_o` unchanged.
- R10: A port A write stores the MCU output byte. A reply capture in the same cycle takes the value the latch held before that write.
- R11: When a host write and a command take fall in the same cycle, two things happen. The take delivers the previously stored byte, and host-sent and `irq_o` stay set for the new byte. When a host read and a reply post fall in the same cycle, MCU-sent stays set.
- R12: Synchronous reset clears all latches, both flags, the previous port B value, the scroll register and `irq_o`, so `pc_rdata_o` reads 0x01 in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = basic mode, 1 = scroll mode with inverted port C status |
| host_wr_i | input | 1 | Host command write strobe |
| host_wdata_i | input | 8 | Host command byte |
| host_rd_i | input | 1 | Host reply read strobe |
| host_rdata_o | output | 8 | Reply byte for the host |
| host_stat_o | output | 8 | Host status: bit 0 host-sent, bit 1 MCU-sent |
| pa_wr_i | input | 1 | MCU port A write strobe |
| pa_wdata_i | input | 8 | MCU port A output byte |
| pa_rdata_o | output | 8 | Command byte delivered to the MCU on port A |
| pb_wr_i | input | 1 | MCU port B write strobe |
| pb_wdata_i | input | 8 | MCU port B value |
| pb_dir_i | input | 8 | Port B direction mask, 1 = line driven |
| pc_rdata_o | output | 8 | MCU port C status byte |
| irq_o | output | 1 | Interrupt request to the MCU |
| scroll_o | output | 16 | Scroll value captured in scroll mode |

## Verification
Two pairs of functions can fall in the same cycle. In the first, the host posts a new command in the very cycle the microcontroller's bit 1 falling edge takes the old one. In the second, the host reads the reply while the bit 2 rising edge posts the next, or while a port A write changes the byte that the post captures. The bench drives both strobes in one cycle. It checks that the take delivers the earlier byte while host-sent and the interrupt stay up, that MCU-sent survives the read, and that the captured reply is the value held before the port A write.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic {
        MODE_BASIC  = 1'b0,
        MODE_SCROLL = 1'b1
    } mbox_mode_e;

    // One-cycle events decoded from a port B write
    typedef struct packed {
        logic take;     // microcontroller takes the host command
        logic post;     // microcontroller posts a reply
        logic scr_lo;   // capture scroll low byte
        logic scr_hi;   // capture scroll high byte
    } pb_evt_t;

    function automatic logic drv_fall(input logic prev, input logic nxt, input logic drv);
        return drv & prev & ~nxt;
    endfunction

    function automatic logic drv_rise(input logic prev, input logic nxt, input logic drv);
        return drv & ~prev & nxt;
    endfunction

endpackage

// File: rtl/mbox_pb_edge.sv
module mbox_pb_edge
    import mbox_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int TAKE_BIT   = 1,
    parameter int POST_BIT   = 2,
    parameter int SCR_LO_BIT = 3,
    parameter int SCR_HI_BIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  mbox_mode_e        mode,
    input  logic              pb_wr,
    input  logic [DATA_W-1:0] pb_wdata,
    input  logic [DATA_W-1:0] pb_dir,
    output logic [DATA_W-1:0] pb_prev,
    output pb_evt_t           evt
);

    logic [DATA_W-1:0] prev_q;
    logic              scroll_en;

    assign scroll_en = (mode == MODE_SCROLL);

    // Previous value follows every port B write, driven or not
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else if (pb_wr) begin
            prev_q <= pb_wdata;
        end
    end

    always_comb begin
        evt = '0;
        if (pb_wr) begin
            evt.take   = drv_fall(prev_q[TAKE_BIT], pb_wdata[TAKE_BIT], pb_dir[TAKE_BIT]);
            evt.post   = drv_rise(prev_q[POST_BIT], pb_wdata[POST_BIT], pb_dir[POST_BIT]);
            evt.scr_lo = scroll_en &
                         drv_fall(prev_q[SCR_LO_BIT], pb_wdata[SCR_LO_BIT], pb_dir[SCR_LO_BIT]);
            evt.scr_hi = scroll_en &
                         drv_fall(prev_q[SCR_HI_BIT], pb_wdata[SCR_HI_BIT], pb_dir[SCR_HI_BIT]);
        end
    end

    assign pb_prev = prev_q;

endmodule

// File: rtl/mbox_xfer.sv
module mbox_xfer
    import mbox_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              pa_wr,
    input  logic [DATA_W-1:0] pa_wdata,
    input  pb_evt_t           evt,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] to_mcu,
    output logic [DATA_W-1:0] mcu_out,
    output logic              host_sent,
    output logic              mcu_sent,
    output logic              irq
);

    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] to_mcu_q;
    logic [DATA_W-1:0] mcu_out_q;
    logic [DATA_W-1:0] reply_q;
    logic              hsent_q;
    logic              msent_q;
    logic              irq_q;

    // Data latches: captures use the values held before this cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            to_mcu_q  <= '0;
            mcu_out_q <= '0;
            reply_q   <= '0;
        end else begin
            if (host_wr)  cmd_q     <= host_wdata;
            if (pa_wr)    mcu_out_q <= pa_wdata;
            if (evt.take) to_mcu_q  <= cmd_q;
            if (evt.post) reply_q   <= mcu_out_q;
        end
    end

    // Flags: a set in the same cycle outranks a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            hsent_q <= 1'b0;
            msent_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (host_wr)       hsent_q <= 1'b1;
            else if (evt.take) hsent_q <= 1'b0;

            if (host_wr)                 irq_q <= 1'b1;
            else if (evt.take && hsent_q) irq_q <= 1'b0;

            if (evt.post)     msent_q <= 1'b1;
            else if (host_rd) msent_q <= 1'b0;
        end
    end

    assign host_rdata = reply_q;
    assign to_mcu     = to_mcu_q;
    assign mcu_out    = mcu_out_q;
    assign host_sent  = hsent_q;
    assign mcu_sent   = msent_q;
    assign irq        = irq_q;

endmodule

// File: rtl/mbox_scroll.sv
module mbox_scroll #(
    parameter int DATA_W = 8,
    parameter int NSEG   = 2,
    localparam int OUT_W = DATA_W * NSEG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSEG-1:0]   load,
    input  logic [DATA_W-1:0] din,
    output logic [OUT_W-1:0]  value
);

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic [DATA_W-1:0] seg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                seg_q <= '0;
            end else if (load[s]) begin
                seg_q <= din;
            end
        end

        assign value[s*DATA_W +: DATA_W] = seg_q;
    end

endmodule

// File: rtl/mbox_hs_ctrl.sv
module mbox_hs_ctrl
    import mbox_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int TAKE_BIT   = 1,
    parameter int POST_BIT   = 2,
    parameter int SCR_LO_BIT = 3,
    parameter int SCR_HI_BIT = 4,
    localparam int SCR_SEGS  = 2,
    localparam int SCR_W     = DATA_W * SCR_SEGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              host_wr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    input  logic              host_rd_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic [DATA_W-1:0] host_stat_o,
    input  logic              pa_wr_i,
    input  logic [DATA_W-1:0] pa_wdata_i,
    output logic [DATA_W-1:0] pa_rdata_o,
    input  logic              pb_wr_i,
    input  logic [DATA_W-1:0] pb_wdata_i,
    input  logic [DATA_W-1:0] pb_dir_i,
    output logic [DATA_W-1:0] pc_rdata_o,
    output logic              irq_o,
    output logic [SCR_W-1:0]  scroll_o
);

    mbox_mode_e        mode;
    pb_evt_t           evt;
    logic [DATA_W-1:0] pb_prev;
    logic [DATA_W-1:0] mcu_out;
    logic              host_sent;
    logic              mcu_sent;
    logic              status_inv;

    assign mode = mbox_mode_e'(mode_i);

    mbox_pb_edge #(
        .DATA_W     (DATA_W),
        .TAKE_BIT   (TAKE_BIT),
        .POST_BIT   (POST_BIT),
        .SCR_LO_BIT (SCR_LO_BIT),
        .SCR_HI_BIT (SCR_HI_BIT)
    ) u_edge (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .pb_wr    (pb_wr_i),
        .pb_wdata (pb_wdata_i),
        .pb_dir   (pb_dir_i),
        .pb_prev  (pb_prev),
        .evt      (evt)
    );

    mbox_xfer #(
        .DATA_W (DATA_W)
    ) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr_i),
        .host_wdata (host_wdata_i),
        .host_rd    (host_rd_i),
        .pa_wr      (pa_wr_i),
        .pa_wdata   (pa_wdata_i),
        .evt        (evt),
        .host_rdata (host_rdata_o),
        .to_mcu     (pa_rdata_o),
        .mcu_out    (mcu_out),
        .host_sent  (host_sent),
        .mcu_sent   (mcu_sent),
        .irq        (irq_o)
    );

    mbox_scroll #(
        .DATA_W (DATA_W),
        .NSEG   (SCR_SEGS)
    ) u_scroll (
        .clk   (clk),
        .rst   (rst),
        .load  ({evt.scr_hi, evt.scr_lo}),
        .din   (mcu_out),
        .value (scroll_o)
    );

    // Status bytes
    assign status_inv = (mode == MODE_SCROLL);

    always_comb begin
        host_stat_o    = '0;
        host_stat_o[0] = host_sent;
        host_stat_o[1] = mcu_sent;
        pc_rdata_o     = '0;
        pc_rdata_o[0]  = ~host_sent ^ status_inv;
        pc_rdata_o[1]  = mcu_sent ^ status_inv;
    end

endmodule

// File: rtl/mbox_hs_ctrl_chk.sv
module mbox_hs_ctrl_chk #(
    parameter int DATA_W     = 8,
    parameter int TAKE_BIT   = 1,
    parameter int POST_BIT   = 2,
    parameter int SCR_W      = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_i,
    input logic              host_wr_i,
    input logic              host_rd_i,
    input logic              pb_wr_i,
    input logic [DATA_W-1:0] pb_wdata_i,
    input logic [DATA_W-1:0] pb_dir_i,
    input logic [DATA_W-1:0] pb_prev,
    input logic [DATA_W-1:0] mcu_out,
    input logic [DATA_W-1:0] host_rdata_o,
    input logic [DATA_W-1:0] host_stat_o,
    input logic [DATA_W-1:0] pa_rdata_o,
    input logic [DATA_W-1:0] pc_rdata_o,
    input logic              irq_o,
    input logic [SCR_W-1:0]  scroll_o
);

    logic take_ev;
    logic post_ev;

    assign take_ev = pb_wr_i && pb_dir_i[TAKE_BIT] && pb_prev[TAKE_BIT] && !pb_wdata_i[TAKE_BIT];
    assign post_ev = pb_wr_i && pb_dir_i[POST_BIT] && !pb_prev[POST_BIT] && pb_wdata_i[POST_BIT];

    a_r1_host_write_flags: assert property (@(posedge clk) disable iff (rst)
        host_wr_i |=> (irq_o && host_stat_o[0]));

    a_r1_irq_follows_flag: assert property (@(posedge clk) disable iff (rst)
        irq_o == host_stat_o[0]);

    a_r2_take_clears: assert property (@(posedge clk) disable iff (rst)
        (take_ev && !host_wr_i) |=> (!irq_o && !host_stat_o[0]));

    a_r3_post_captures: assert property (@(posedge clk) disable iff (rst)
        post_ev |=> (host_stat_o[1] && host_rdata_o == $past(mcu_out)));

    a_r5_undriven_take_inert: assert property (@(posedge clk) disable iff (rst)
        (pb_wr_i && !pb_dir_i[TAKE_BIT]) |=> $stable(pa_rdata_o));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (host_rd_i && !post_ev) |=> !host_stat_o[1]);

    a_r8_portc_polarity: assert property (@(posedge clk) disable iff (rst)
        pc_rdata_o[1:0] == ({host_stat_o[1], ~host_stat_o[0]} ^ {2{mode_i}}));

    a_r9_scroll_hold_basic: assert property (@(posedge clk) disable iff (rst)
        !mode_i |=> $stable(scroll_o));

endmodule

bind mbox_hs_ctrl mbox_hs_ctrl_chk #(
    .DATA_W   (DATA_W),
    .TAKE_BIT (TAKE_BIT),
    .POST_BIT (POST_BIT),
    .SCR_W    (SCR_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .host_wr_i    (host_wr_i),
    .host_rd_i    (host_rd_i),
    .pb_wr_i      (pb_wr_i),
    .pb_wdata_i   (pb_wdata_i),
    .pb_dir_i     (pb_dir_i),
    .pb_prev      (pb_prev),
    .mcu_out      (mcu_out),
    .host_rdata_o (host_rdata_o),
    .host_stat_o  (host_stat_o),
    .pa_rdata_o   (pa_rdata_o),
    .pc_rdata_o   (pc_rdata_o),
    .irq_o        (irq_o),
    .scroll_o     (scroll_o)
);

// File: tb/mbox_hs_ctrl_tb_top.sv
module mbox_hs_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_i = 1'b0;
    logic        host_wr_i = 1'b0;
    logic [7:0]  host_wdata_i = '0;
    logic        host_rd_i = 1'b0;
    logic [7:0]  host_rdata_o;
    logic [7:0]  host_stat_o;
    logic        pa_wr_i = 1'b0;
    logic [7:0]  pa_wdata_i = '0;
    logic [7:0]  pa_rdata_o;
    logic        pb_wr_i = 1'b0;
    logic [7:0]  pb_wdata_i = '0;
    logic [7:0]  pb_dir_i = '0;
    logic [7:0]  pc_rdata_o;
    logic        irq_o;
    logic [15:0] scroll_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mbox_hs_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (mode_i),
        .host_wr_i    (host_wr_i),
        .host_wdata_i (host_wdata_i),
        .host_rd_i    (host_rd_i),
        .host_rdata_o (host_rdata_o),
        .host_stat_o  (host_stat_o),
        .pa_wr_i      (pa_wr_i),
        .pa_wdata_i   (pa_wdata_i),
        .pa_rdata_o   (pa_rdata_o),
        .pb_wr_i      (pb_wr_i),
        .pb_wdata_i   (pb_wdata_i),
        .pb_dir_i     (pb_dir_i),
        .pc_rdata_o   (pc_rdata_o),
        .irq_o        (irq_o),
        .scroll_o     (scroll_o)
    );

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One clock of stimulus; any combination of strobes; returns at the next falling edge
    task automatic step(input bit hw, input logic [7:0] hd, input bit hr,
                        input bit aw, input logic [7:0] ad,
                        input bit bw, input logic [7:0] bd, input logic [7:0] bdir);
        @(negedge clk);
        host_wr_i = hw; host_wdata_i = hd; host_rd_i = hr;
        pa_wr_i = aw;   pa_wdata_i = ad;
        pb_wr_i = bw;   pb_wdata_i = bd;   pb_dir_i = bdir;
        @(negedge clk);
        host_wr_i = 1'b0; host_rd_i = 1'b0; pa_wr_i = 1'b0; pb_wr_i = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d); step(1, d, 0, 0, 8'h00, 0, 8'h00, 8'h00); endtask
    task automatic host_read();                     step(0, 8'h00, 1, 0, 8'h00, 0, 8'h00, 8'h00); endtask
    task automatic pa_write(input logic [7:0] d);   step(0, 8'h00, 0, 1, d, 0, 8'h00, 8'h00); endtask
    task automatic pb_write(input logic [7:0] d, input logic [7:0] dir); step(0, 8'h00, 0, 0, 8'h00, 1, d, dir); endtask

    task automatic t_reset();
        check("R12", "pc_rdata", pc_rdata_o, 16'h01);
        check("R12", "irq", irq_o, 16'h0);
        check("R12", "host_stat", host_stat_o, 16'h00);
        check("R12", "host_rdata", host_rdata_o, 16'h00);
        check("R12", "pa_rdata", pa_rdata_o, 16'h00);
        check("R12", "scroll", scroll_o, 16'h0000);
    endtask

    task automatic t_command();
        host_write(8'hA5);
        check("R1", "host_stat after write", host_stat_o, 16'h01);
        check("R1", "irq after write", irq_o, 16'h1);
        check("R8", "pc mode0 pending cmd", pc_rdata_o, 16'h00);
        pb_write(8'h02, 8'h06);              // bit 1 rises: not a take
        check("R4", "rise on take bit ignored", pa_rdata_o, 16'h00);
        check("R4", "host-sent kept", host_stat_o, 16'h01);
        pb_write(8'h00, 8'h06);              // bit 1 falls: take
        check("R2", "pa_rdata after take", pa_rdata_o, 16'hA5);
        check("R2", "host_stat after take", host_stat_o, 16'h00);
        check("R2", "irq after take", irq_o, 16'h0);
        check("R8", "pc mode0 idle", pc_rdata_o, 16'h01);
    endtask

    task automatic t_reply();
        pa_write(8'h3C);
        pb_write(8'h04, 8'h06);              // bit 2 rises: post
        check("R3", "host_rdata after post", host_rdata_o, 16'h3C);
        check("R7", "host_stat after post", host_stat_o, 16'h02);
        check("R8", "pc mode0 reply", pc_rdata_o, 16'h03);
        pa_write(8'h11);
        pb_write(8'h04, 8'h06);              // same level again: no edge
        check("R4", "repeat level no capture", host_rdata_o, 16'h3C);
        host_read();
        check("R6", "host_stat after read", host_stat_o, 16'h00);
        check("R8", "pc after read", pc_rdata_o, 16'h01);
    endtask

    task automatic t_undriven();
        pb_write(8'h00, 8'h06);              // baseline, bit 2 falls (no event)
        host_write(8'h5A);
        pb_write(8'h02, 8'h00);
        pb_write(8'h00, 8'h00);              // undriven take edge
        check("R5", "undriven take: pa_rdata", pa_rdata_o, 16'hA5);
        check("R5", "undriven take: irq", irq_o, 16'h1);
        pb_write(8'h02, 8'h00);              // prev updated while undriven
        pb_write(8'h00, 8'h02);              // driven fall against that prev
        check("R4", "prev follows undriven write", pa_rdata_o, 16'h5A);
        check("R2", "irq cleared", irq_o, 16'h0);
        pa_write(8'h77);
        pb_write(8'h04, 8'h02);              // bit 2 rises but undriven
        check("R5", "undriven post: host_rdata", host_rdata_o, 16'h3C);
        check("R5", "undriven post: host_stat", host_stat_o, 16'h00);
    endtask

    task automatic t_collide();
        host_write(8'h10);
        pb_write(8'h06, 8'h06);              // bit 1 up
        step(1, 8'h20, 0, 0, 8'h00, 1, 8'h04, 8'h06);   // host write + take together
        check("R11", "take gets older byte", pa_rdata_o, 16'h10);
        check("R11", "host-sent stays", host_stat_o, 16'h01);
        check("R11", "irq stays", irq_o, 16'h1);
        pb_write(8'h06, 8'h06);
        pb_write(8'h04, 8'h06);
        check("R2", "second take gets new byte", pa_rdata_o, 16'h20);
        check("R2", "host-sent cleared", host_stat_o, 16'h00);
        pb_write(8'h00, 8'h06);              // bit 2 low
        pa_write(8'h99);
        step(0, 8'h00, 1, 0, 8'h00, 1, 8'h04, 8'h06);   // host read + post together
        check("R11", "mcu-sent survives read", host_stat_o, 16'h02);
        check("R3", "reply captured", host_rdata_o, 16'h99);
        pb_write(8'h00, 8'h06);
        step(0, 8'h00, 0, 1, 8'hEE, 1, 8'h04, 8'h06);   // port A write + post together
        check("R10", "post takes old latch", host_rdata_o, 16'h99);
        pb_write(8'h00, 8'h06);
        pb_write(8'h04, 8'h06);
        check("R10", "post takes new latch", host_rdata_o, 16'hEE);
    endtask

    task automatic t_scroll_basic();
        pa_write(8'h55);
        pb_write(8'h1C, 8'h1E);
        pb_write(8'h04, 8'h1E);              // bits 3 and 4 fall in mode 0
        check("R9", "mode0 scroll unchanged", scroll_o, 16'h0000);
    endtask

    task automatic t_scroll_mode();
        mode_i = 1'b1;
        @(negedge clk);
        check("R8", "pc mode1 reply pending", pc_rdata_o, 16'h00);
        host_read();
        check("R8", "pc mode1 idle", pc_rdata_o, 16'h02);
        host_write(8'h42);
        check("R8", "pc mode1 cmd pending", pc_rdata_o, 16'h03);
        pb_write(8'h06, 8'h06);
        pb_write(8'h04, 8'h06);              // take to leave host-sent clear
        pa_write(8'h34);
        pb_write(8'h1C, 8'h1E);
        pb_write(8'h14, 8'h1E);              // bit 3 falls
        check("R9", "scroll low loaded", scroll_o, 16'h0034);
        pa_write(8'h12);
        pb_write(8'h04, 8'h1E);              // bit 4 falls
        check("R9", "scroll high loaded", scroll_o, 16'h1234);
        pa_write(8'h9A);
        pb_write(8'h1C, 8'h06);
        pb_write(8'h04, 8'h06);              // undriven scroll edges
        check("R5", "undriven scroll edges", scroll_o, 16'h1234);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_command();
        t_reply();
        t_undriven();
        t_collide();
        t_scroll_basic();
        t_scroll_mode();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule